// File: doc/BRIEF.md
# Segment Offset Limit Checker and Linear Address Generator

This block sits in the address path of a segmented memory unit. A descriptor is loaded into it once, with a load strobe. The descriptor carries a 32-bit base, a 20-bit limit, a granularity flag, a bound-size flag and a direction flag. After that, every access presents a 32-bit offset together with a request valid. One clock later the block returns three things: the 32-bit linear address, a response valid and a general-protection fault flag.

Only the offset is judged. For a segment that grows upward, the offset must not exceed a ceiling derived from the limit. For a segment that grows downward, the test is reversed: the offset must reach a floor derived from the limit, and it may not pass a top that the bound flag selects. The linear address is the base plus the offset, kept to 32 bits. A carry out of that sum wraps and is never a fault. Every access is a single-byte reference.

Top module: `seg_xlate`

## Requirements
- R1: A synchronous active-high reset clears the held descriptor (base 0, limit 0, all flags 0, meaning an upward segment with ceiling 0). It also drives rsp_vld, rsp_gp and rsp_lin to 0.
- R2: rsp_vld equals req_vld of the previous cycle. rsp_gp is never 1 while rsp_vld is 0.
- R3: Upward segment (dir flag 0): the access is legal exactly when offset <= ceiling. The ceiling is {limit, 12'hFFF} when gran is 1 and the zero-extended limit when gran is 0. The bound flag has no effect on an upward segment.
- R4: Downward segment (dir flag 1) with the bound flag set to 1: the access is legal exactly when offset >= floor. The floor is limit shifted left by 12 when gran is 1 and the zero-extended limit when gran is 0. For example, limit 0xFFFFF with gran 1 accepts offsets 0xFFFFF000 through 0xFFFFFFFF.
- R5: Downward segment with the bound flag set to 0: the access is legal exactly when floor <= offset <= 0xFFFF. Any offset above 0xFFFF faults.
- R6: For a legal access, rsp_lin = (base + offset) mod 2^32. A carry out of the sum never raises rsp_gp. For example, base 0x1 and offset 0xFFFFFFFF give 0x0.
- R7: For an illegal access, rsp_gp is 1 and rsp_lin is 0.
- R8: desc_ld captures all five descriptor inputs. The new descriptor governs accesses presented in the cycles after the strobe. An access presented in the same cycle as the strobe is judged against the previous descriptor.
- R9: Lowering the limit of a downward segment moves its floor down and leaves its top where it was. Offsets that were legal remain legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_ld | input | 1 | Descriptor load strobe |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 20 | Raw segment limit |
| desc_gran | input | 1 | 1: limit counts 4 KB units |
| desc_big | input | 1 | Downward top: 1 selects 0xFFFFFFFF, 0 selects 0xFFFF |
| desc_down | input | 1 | 1: downward-growing segment |
| req_vld | input | 1 | Access request valid |
| req_off | input | 32 | Segment-relative offset |
| rsp_vld | output | 1 | Response valid, one cycle after request |
| rsp_lin | output | 32 | Linear address (0 on fault) |
| rsp_gp | output | 1 | General-protection fault |

## Verification
A descriptor load and an access can fall in the same cycle. When they do, the access must be judged against the old descriptor, and the new one must take effect only on the next access. The bench provokes this by first loading an upward segment. It then raises the strobe with a downward segment in the same cycle as an offset that only the old descriptor accepts. The first response must be a legal translation through the old base. Repeating the offset one cycle later must fault under the new descriptor.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SEG_AW  = 32;
  localparam int SEG_LW  = 20;
  localparam int SEG_GSH = 12;
  localparam int SEG_SW  = 16;

  typedef struct packed {
    logic [SEG_AW-1:0] base;
    logic [SEG_LW-1:0] limit;
    logic              gran;
    logic              big;
    logic              down;
  } seg_desc_t;

  // Highest legal offset of an upward segment.
  function automatic logic [SEG_AW-1:0] up_ceiling(input logic [SEG_LW-1:0] lim,
                                                   input logic gran);
    if (gran) return {lim, {SEG_GSH{1'b1}}};
    return {{(SEG_AW-SEG_LW){1'b0}}, lim};
  endfunction

  // Lowest legal offset of a downward segment.
  function automatic logic [SEG_AW-1:0] down_floor(input logic [SEG_LW-1:0] lim,
                                                   input logic gran);
    if (gran) return {lim, {SEG_GSH{1'b0}}};
    return {{(SEG_AW-SEG_LW){1'b0}}, lim};
  endfunction

  // Offset lies above the small (16-bit) downward top.
  function automatic logic above_small(input logic [SEG_AW-1:0] off);
    return |off[SEG_AW-1:SEG_SW];
  endfunction

  // Modulo-2^AW translation; carry returned separately, never used as a fault.
  function automatic logic [SEG_AW:0] wide_sum(input logic [SEG_AW-1:0] base,
                                               input logic [SEG_AW-1:0] off);
    return {1'b0, base} + {1'b0, off};
  endfunction

endpackage

// File: rtl/seg_desc_reg.sv
module seg_desc_reg
  import seg_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ld,
  input  seg_desc_t d_in,
  output seg_desc_t d_cur
);

  always_ff @(posedge clk) begin
    if (rst)     d_cur <= '0;
    else if (ld) d_cur <= d_in;
  end

  AST_LOAD_TAKES : assert property (@(posedge clk) disable iff (rst)
    ld |=> d_cur == $past(d_in)); // R8
  AST_HOLD_IDLE : assert property (@(posedge clk) disable iff (rst)
    (!ld && !$past(rst)) |=> $stable(d_cur)); // R8

endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
  import seg_xlate_pkg::*;
#(
  parameter int AW = SEG_AW
) (
  input  seg_desc_t     desc,
  input  logic [AW-1:0] off,
  output logic [AW-1:0] ceil_w,
  output logic [AW-1:0] floor_w,
  output logic          small_over_w,
  output logic          fault_w
);

  always_comb begin
    ceil_w       = up_ceiling(desc.limit, desc.gran);
    floor_w      = down_floor(desc.limit, desc.gran);
    small_over_w = above_small(off);
    if (desc.down)
      fault_w = (off < floor_w) || (!desc.big && small_over_w);
    else
      fault_w = (off > ceil_w);
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlate_pkg::*;
#(
  parameter int AW = SEG_AW
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] off,
  output logic [AW-1:0] sum_w,
  output logic          carry_w
);

  logic [AW:0] full;

  always_comb begin
    full    = wide_sum(base, off);
    sum_w   = full[AW-1:0];
    carry_w = full[AW];
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int AW = SEG_AW,
  parameter int LW = SEG_LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          desc_ld,
  input  logic [AW-1:0] desc_base,
  input  logic [LW-1:0] desc_limit,
  input  logic          desc_gran,
  input  logic          desc_big,
  input  logic          desc_down,
  input  logic          req_vld,
  input  logic [AW-1:0] req_off,
  output logic          rsp_vld,
  output logic [AW-1:0] rsp_lin,
  output logic          rsp_gp
);

  seg_desc_t     d_in, d_cur;
  logic [AW-1:0] ceil_w, floor_w, sum_w;
  logic          small_over_w, fault_w, carry_w;

  assign d_in = '{base: desc_base, limit: desc_limit, gran: desc_gran,
                  big: desc_big, down: desc_down};

  seg_desc_reg u_desc (
    .clk(clk), .rst(rst), .ld(desc_ld), .d_in(d_in), .d_cur(d_cur)
  );

  seg_limit_chk #(.AW(AW)) u_chk (
    .desc(d_cur), .off(req_off), .ceil_w(ceil_w), .floor_w(floor_w),
    .small_over_w(small_over_w), .fault_w(fault_w)
  );

  seg_addr_gen #(.AW(AW)) u_add (
    .base(d_cur.base), .off(req_off), .sum_w(sum_w), .carry_w(carry_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld <= 1'b0;
      rsp_gp  <= 1'b0;
      rsp_lin <= '0;
    end else begin
      rsp_vld <= req_vld;
      rsp_gp  <= req_vld && fault_w;
      rsp_lin <= (req_vld && !fault_w) ? sum_w : '0;
    end
  end

  AST_VLD_FOLLOWS : assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld); // R2
  AST_VLD_IDLE : assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !rsp_vld); // R2
  AST_GP_QUALIFIED : assert property (@(posedge clk) disable iff (rst)
    rsp_gp |-> rsp_vld); // R2
  AST_GP_ZERO_LIN : assert property (@(posedge clk) disable iff (rst)
    rsp_gp |-> rsp_lin == '0); // R7
  AST_SMALL_TOP : assert property (@(posedge clk) disable iff (rst)
    (req_vld && d_cur.down && !d_cur.big && small_over_w) |=> rsp_gp); // R5
  AST_UP_IN_RANGE : assert property (@(posedge clk) disable iff (rst)
    (req_vld && !d_cur.down && req_off <= ceil_w) |=> !rsp_gp); // R3
  AST_DOWN_BELOW : assert property (@(posedge clk) disable iff (rst)
    (req_vld && d_cur.down && req_off < floor_w) |=> rsp_gp); // R4
  AST_CARRY_WRAPS : assert property (@(posedge clk) disable iff (rst)
    (req_vld && carry_w && !fault_w) |=> (!rsp_gp && rsp_lin == $past(sum_w))); // R6

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

  logic        clk = 1'b0;
  logic        rst;
  logic        desc_ld;
  logic [31:0] desc_base;
  logic [19:0] desc_limit;
  logic        desc_gran, desc_big, desc_down;
  logic        req_vld;
  logic [31:0] req_off;
  logic        rsp_vld;
  logic [31:0] rsp_lin;
  logic        rsp_gp;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  seg_xlate i_seg_xlate (
    .clk(clk), .rst(rst), .desc_ld(desc_ld), .desc_base(desc_base),
    .desc_limit(desc_limit), .desc_gran(desc_gran), .desc_big(desc_big),
    .desc_down(desc_down), .req_vld(req_vld), .req_off(req_off),
    .rsp_vld(rsp_vld), .rsp_lin(rsp_lin), .rsp_gp(rsp_gp)
  );

  // {base, limit, gran, big, down, off, exp_gp, exp_lin}
  localparam int NV = 15;
  localparam logic [119:0] VEC [NV] = '{
    {32'h0000_1000, 20'h00FFF, 1'b0, 1'b1, 1'b0, 32'h0000_0FFF, 1'b0, 32'h0000_1FFF}, // R3 edge
    {32'h0000_1000, 20'h00FFF, 1'b0, 1'b1, 1'b0, 32'h0000_1000, 1'b1, 32'h0},         // R3 over
    {32'h0000_0010, 20'h00001, 1'b1, 1'b0, 1'b0, 32'h0000_1FFF, 1'b0, 32'h0000_200F}, // R3 gran
    {32'h0000_0010, 20'h00001, 1'b1, 1'b0, 1'b0, 32'h0000_2000, 1'b1, 32'h0},         // R3 gran over
    {32'h0000_0001, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0},         // R4 R6 wrap
    {32'h0000_0001, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 32'hFFFF_F000, 1'b0, 32'hFFFF_F001}, // R4 floor
    {32'h0000_0001, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 32'hFFFF_EFFF, 1'b1, 32'h0},         // R4 below
    {32'h0002_0000, 20'h00100, 1'b0, 1'b0, 1'b1, 32'h0000_0100, 1'b0, 32'h0002_0100}, // R5 floor
    {32'h0002_0000, 20'h00100, 1'b0, 1'b0, 1'b1, 32'h0000_00FF, 1'b1, 32'h0},         // R5 below
    {32'h0002_0000, 20'h00100, 1'b0, 1'b0, 1'b1, 32'h0000_FFFF, 1'b0, 32'h0002_FFFF}, // R5 top
    {32'h0002_0000, 20'h00100, 1'b0, 1'b0, 1'b1, 32'h0001_0000, 1'b1, 32'h0},         // R5 above
    {32'h0000_0000, 20'hFFFF0, 1'b1, 1'b1, 1'b1, 32'hFFFF_0000, 1'b0, 32'hFFFF_0000}, // R9 lower floor
    {32'h0000_0000, 20'hFFFF0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF}, // R9 top fixed
    {32'hFFFF_FFF0, 20'hFFFFF, 1'b0, 1'b0, 1'b0, 32'h0000_0020, 1'b0, 32'h0000_0010}, // R6 R3 big ignored
    {32'h8000_0000, 20'h00000, 1'b0, 1'b1, 1'b1, 32'h8000_0000, 1'b0, 32'h0}          // R6 carry no fault
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] b, input logic [19:0] l,
                      input logic g, input logic bg, input logic dn);
    desc_ld = 1'b1; desc_base = b; desc_limit = l;
    desc_gran = g; desc_big = bg; desc_down = dn;
    @(negedge clk);
    desc_ld = 1'b0;
  endtask

  task automatic access(input logic [31:0] off);
    req_vld = 1'b1; req_off = off;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; desc_ld = 1'b0; desc_base = '0; desc_limit = '0;
    desc_gran = 1'b0; desc_big = 1'b0; desc_down = 1'b0;
    req_vld = 1'b1; req_off = 32'h5;
    repeat (3) @(negedge clk);
    chk("R1 vld", {31'b0, rsp_vld}, 32'h0);
    chk("R1 gp", {31'b0, rsp_gp}, 32'h0);
    chk("R1 lin", rsp_lin, 32'h0);
    req_vld = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // R1: cleared descriptor is an upward segment with ceiling 0
    access(32'h0);
    chk("R1 off0 gp", {31'b0, rsp_gp}, 32'h0);
    chk("R1 off0 lin", rsp_lin, 32'h0);
    access(32'h1);
    chk("R1 off1 gp", {31'b0, rsp_gp}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i][119:88], VEC[i][87:68], VEC[i][67], VEC[i][66], VEC[i][65]);
      access(VEC[i][64:33]);
      chk($sformatf("R2 vec%0d vld", i), {31'b0, rsp_vld}, 32'h1);
      chk($sformatf("R3/R4/R5 vec%0d gp", i), {31'b0, rsp_gp}, {31'b0, VEC[i][32]});
      chk($sformatf("R6/R7 vec%0d lin", i), rsp_lin, VEC[i][31:0]);
    end

    // R2: idle cycle gives no response and no fault
    @(negedge clk);
    chk("R2 idle vld", {31'b0, rsp_vld}, 32'h0);
    chk("R2 idle gp", {31'b0, rsp_gp}, 32'h0);

    // R8: strobe and access in the same cycle
    load(32'h0000_4000, 20'h00FFF, 1'b0, 1'b1, 1'b0);
    desc_ld = 1'b1; desc_base = 32'h0; desc_limit = 20'hFFFFF;
    desc_gran = 1'b1; desc_big = 1'b1; desc_down = 1'b1;
    req_vld = 1'b1; req_off = 32'h10;
    @(negedge clk);
    desc_ld = 1'b0; req_vld = 1'b0;
    chk("R8 same-cycle gp", {31'b0, rsp_gp}, 32'h0);
    chk("R8 same-cycle lin", rsp_lin, 32'h0000_4010);
    access(32'h10);
    chk("R8 next gp", {31'b0, rsp_gp}, 32'h1);
    chk("R7 next lin", rsp_lin, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule